// File: doc/BRIEF.md
# Region Access Permission Checker

This block decides, for one bus access per cycle, whether the access may proceed under a set of memory protection regions. Each region carries an address window, per-master rights, an optional process-identifier match and a valid bit. All regions are evaluated at the same time. The block returns a registered grant or fault one clock after the access is presented. It also returns the set of regions that matched and a classification of the match, which an error logger can record when the access is refused.

The checked access is described by its address, the number of the requesting master, the kind of access (data read, data write or instruction fetch), the privilege level and a process identifier. The lower-numbered masters have full rights fields: a user-mode field and a supervisor-mode field with an escape to the user field. The higher-numbered masters carry only read and write enables. The region table is supplied as one flat vector by the surrounding logic. A global enable switches checking off; while it is off, every access is granted.

Top module: `prot_access_check`

## Requirements
- R1: An access hits a valid region when the address bits above bit 4 lie between the same bits of the region's low and high bounds, inclusive. Bits 4..0 of both bounds are ignored, so a window always starts on a 32-byte boundary and ends on the last byte of a 32-byte block.
- R2: A region whose valid bit is 0 never contributes a hit, whatever its bounds.
- R3: For a full-rights master (number below NFULL) in user mode (`acc_super`=0), the 3-bit user field grants read with bit 2, write with bit 1 and execute with bit 0. A value of 0 grants nothing.
- R4: For a full-rights master in supervisor mode, the 2-bit supervisor field selects the rights: 0 gives read, write and execute; 1 gives read and execute; 2 gives read and write; 3 uses the user field.
- R5: A read/write-only master (number NFULL to NFULL+NRW-1) uses bit 1 of its 2-bit field as read enable and bit 0 as write enable. It never gets execute rights. Its privilege level and process identifier have no effect.
- R6: When the process-identifier enable bit of a full-rights master is set in a region, that region counts as hit only if `acc_pid` equals the region identifier on every bit where the region mask is 0.
- R7: When `glb_en` is 0, every presented access is granted. The hit set and the classification are still reported.
- R8: When several regions are hit, the access is granted if any one of them gives the needed right.
- R9: `res_hits` holds one bit per hit region. `res_class` is 0 when no region is hit, 1 when exactly one is hit and 2 when two or more are hit. A no-hit access with `glb_en`=1 is always refused.
- R10: The result appears on the clock edge after `acc_valid` is high: `res_valid` follows `acc_valid` by one cycle. While `res_valid` is 0, the grant, fault, class and hit outputs are 0, and exactly one of grant and fault is 1 while it is 1. Reset clears all outputs.
- R11: `acc_kind` 2'b00 is a data read needing read rights, 2'b01 is a data write needing write rights, and 2'b10 or 2'b11 is an instruction fetch needing execute rights.
- R12: Region i occupies `desc_flat[i*DW +: DW]`, with these fields:
  - low bound at bit 0 (AW bits);
  - high bound at AW (AW bits);
  - full-master fields at 2*AW, 6 bits per master m at offset 6*m, arranged as user[2:0], supervisor[4:3] and pid-enable[5];
  - read/write fields after them, 2 bits per master;
  - region identifier (PW bits), then identifier mask (PW bits);
  - valid bit last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global checking enable |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Access address |
| acc_master | input | MW | Requesting master number |
| acc_kind | input | 2 | Access kind: read, write or fetch |
| acc_super | input | 1 | 1 for supervisor, 0 for user |
| acc_pid | input | PW | Process identifier of the access |
| desc_flat | input | NREG*DW | Packed region table |
| res_valid | output | 1 | Result present |
| res_grant | output | 1 | Access allowed |
| res_fault | output | 1 | Access refused |
| res_class | output | 2 | Hit classification |
| res_hits | output | NREG | Regions hit |

## Verification
The hardest case to reach is the overlap of two regions that give different rights. Here the outcome depends on whether any one region grants the right, and also on whether the process-identifier filter has silently dropped one region from the hit set. The bench places two windows that share a block, plus a one-block window with identifier matching, and a disabled region over its own range. For several rights tables, it then sweeps every master, access kind, privilege level and global-enable value, with identifiers that match and that fail on unmasked bits. The same sweep uses bounds whose low bits are deliberately nonzero and addresses on both sides of each 32-byte edge.

// File: rtl/prot_access_check.sv
module prot_access_check #(
  parameter int AW    = 32,
  parameter int PW    = 8,
  parameter int NREG  = 4,
  parameter int NFULL = 4,
  parameter int NRW   = 4,
  localparam int MW    = $clog2(NFULL + NRW),
  localparam int O_LO  = 0,
  localparam int O_HI  = AW,
  localparam int O_RWX = 2 * AW,
  localparam int O_RW  = O_RWX + 6 * NFULL,
  localparam int O_PID = O_RW + 2 * NRW,
  localparam int O_MSK = O_PID + PW,
  localparam int O_VLD = O_MSK + PW,
  localparam int DW    = O_VLD + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 glb_en,
  input  logic                 acc_valid,
  input  logic [AW-1:0]        acc_addr,
  input  logic [MW-1:0]        acc_master,
  input  logic [1:0]           acc_kind,
  input  logic                 acc_super,
  input  logic [PW-1:0]        acc_pid,
  input  logic [NREG*DW-1:0]   desc_flat,
  output logic                 res_valid,
  output logic                 res_grant,
  output logic                 res_fault,
  output logic [1:0]           res_class,
  output logic [NREG-1:0]      res_hits
);

  logic [NREG-1:0] hit, ok, unused_lsb;
  logic [2:0]      need;
  logic            multi, grant;
  logic [1:0]      cls;
  logic            unused_addr;

  assign unused_addr = ^acc_addr[4:0];
  assign need  = acc_kind[1] ? 3'b001 : (acc_kind[0] ? 3'b010 : 3'b100);

  always_comb begin
    logic [DW-1:0]   d;
    logic [AW-6:0]   a, lo, hi;
    logic [5:0]      f;
    logic [1:0]      rw;
    logic [2:0]      eff;
    logic            pid_ok;
    int              m;
    m = int'(acc_master);
    a = acc_addr[AW-1:5];
    for (int i = 0; i < NREG; i++) begin
      d   = desc_flat[i*DW +: DW];
      lo  = d[O_LO+5 +: AW-5];
      hi  = d[O_HI+5 +: AW-5];
      unused_lsb[i] = ^{d[O_LO +: 5], d[O_HI +: 5]};
      eff = 3'b000;
      pid_ok = 1'b1;
      f  = '0;
      rw = '0;
      if (m < NFULL) begin
        f = d[O_RWX + 6*m +: 6];
        if (!acc_super) eff = f[2:0];
        else begin
          case (f[4:3])
            2'd0:    eff = 3'b111;
            2'd1:    eff = 3'b101;
            2'd2:    eff = 3'b110;
            default: eff = f[2:0];
          endcase
        end
        pid_ok = !f[5] || (((acc_pid ^ d[O_PID +: PW]) & ~d[O_MSK +: PW]) == '0);
      end else if (m < NFULL + NRW) begin
        rw  = d[O_RW + 2*(m-NFULL) +: 2];
        eff = {rw[1], rw[0], 1'b0};
      end
      hit[i] = d[O_VLD] && (a >= lo) && (a <= hi) && pid_ok;
      ok[i]  = hit[i] && |(eff & need);
    end
  end

  assign multi = |(hit & (hit - 1'b1));
  assign cls   = !(|hit) ? 2'd0 : (multi ? 2'd2 : 2'd1);
  assign grant = !glb_en || |ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_grant <= 1'b0;
      res_fault <= 1'b0;
      res_class <= 2'd0;
      res_hits  <= '0;
    end else begin
      res_valid <= acc_valid;
      res_grant <= acc_valid && grant;
      res_fault <= acc_valid && !grant;
      res_class <= acc_valid ? cls : 2'd0;
      res_hits  <= acc_valid ? hit : '0;
    end
  end

endmodule

// File: rtl/prot_access_check_sva.sv
module prot_access_check_sva #(
  parameter int NREG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            glb_en,
  input logic            acc_valid,
  input logic            res_valid,
  input logic            res_grant,
  input logic            res_fault,
  input logic [1:0]      res_class,
  input logic [NREG-1:0] res_hits
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (res_valid == $past(acc_valid)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_grant && !res_fault && res_class == 2'd0 && res_hits == '0));

  a_r10_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_grant != res_fault));

  a_r9_class_count: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_class == 2'd0 && res_hits == '0) ||
                   (res_class == 2'd1 && $countones(res_hits) == 1) ||
                   (res_class == 2'd2 && $countones(res_hits) >= 2)));

  a_r9_nohit_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && res_valid && $past(glb_en) && res_hits == '0) |-> res_fault);

  a_r7_disabled_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && res_valid && !$past(glb_en)) |-> res_grant);

endmodule

bind prot_access_check prot_access_check_sva #(.NREG(NREG)) u_sva (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .acc_valid(acc_valid),
  .res_valid(res_valid), .res_grant(res_grant), .res_fault(res_fault),
  .res_class(res_class), .res_hits(res_hits)
);

// File: tb/sim_prot_access_check.sv
module sim_prot_access_check;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, PW = 8, NREG = 4, NFULL = 4, NRW = 4;
  localparam int MW = $clog2(NFULL + NRW);
  localparam int O_RWX = 2 * AW, O_RW = O_RWX + 6 * NFULL;
  localparam int O_PID = O_RW + 2 * NRW, O_MSK = O_PID + PW, O_VLD = O_MSK + PW;
  localparam int DW = O_VLD + 1;

  logic clk = 0, rst_n = 0, glb_en = 0, acc_valid = 0, acc_super = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [MW-1:0] acc_master = '0;
  logic [1:0] acc_kind = '0;
  logic [PW-1:0] acc_pid = '0;
  logic [NREG*DW-1:0] desc_flat = '0;
  logic res_valid, res_grant, res_fault;
  logic [1:0] res_class;
  logic [NREG-1:0] res_hits;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_access_check #(.AW(AW), .PW(PW), .NREG(NREG), .NFULL(NFULL), .NRW(NRW)) u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_master(acc_master), .acc_kind(acc_kind),
    .acc_super(acc_super), .acc_pid(acc_pid), .desc_flat(desc_flat),
    .res_valid(res_valid), .res_grant(res_grant), .res_fault(res_fault),
    .res_class(res_class), .res_hits(res_hits));

  logic [AW-1:0] r_lo [NREG], r_hi [NREG];
  logic          r_vld [NREG];
  logic [5:0]    r_rx [NREG][NFULL];
  logic [1:0]    r_rw [NREG][NRW];
  logic [PW-1:0] r_pid [NREG], r_msk [NREG];

  logic          e_grant;
  logic [1:0]    e_cls;
  logic [NREG-1:0] e_hits;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R12 descriptor layout
  task automatic pack();
    for (int r = 0; r < NREG; r++) begin
      desc_flat[r*DW +: AW] = r_lo[r];
      desc_flat[r*DW + AW +: AW] = r_hi[r];
      for (int m = 0; m < NFULL; m++) desc_flat[r*DW + O_RWX + 6*m +: 6] = r_rx[r][m];
      for (int m = 0; m < NRW; m++) desc_flat[r*DW + O_RW + 2*m +: 2] = r_rw[r][m];
      desc_flat[r*DW + O_PID +: PW] = r_pid[r];
      desc_flat[r*DW + O_MSK +: PW] = r_msk[r];
      desc_flat[r*DW + O_VLD] = r_vld[r];
    end
  endtask

  task automatic model(input logic [AW-1:0] ad, input int m, input int kind,
                       input bit sup, input logic [PW-1:0] pid, input bit en);
    int cnt;
    bit any_ok, rd, wr, ex, pid_ok, inr, need_ok;
    logic [2:0] u;
    logic [1:0] s;
    cnt = 0; any_ok = 0; e_hits = '0;
    for (int r = 0; r < NREG; r++) begin
      inr = r_vld[r] && ad >= (r_lo[r] & ~32'h1F) && ad <= (r_hi[r] | 32'h1F);
      if (m < NFULL) begin
        u = r_rx[r][m][2:0]; s = r_rx[r][m][4:3];
        if (!sup) begin rd = u[2]; wr = u[1]; ex = u[0]; end
        else begin
          rd = (s != 3) || u[2];
          wr = (s == 0) || (s == 2) || (s == 3 && u[1]);
          ex = (s == 0) || (s == 1) || (s == 3 && u[0]);
        end
        pid_ok = !r_rx[r][m][5] || ((pid & ~r_msk[r]) == (r_pid[r] & ~r_msk[r]));
      end else begin
        rd = r_rw[r][m-NFULL][1]; wr = r_rw[r][m-NFULL][0]; ex = 0; pid_ok = 1;
      end
      need_ok = (kind >= 2) ? ex : ((kind == 1) ? wr : rd);
      if (inr && pid_ok) begin
        e_hits[r] = 1'b1; cnt++;
        if (need_ok) any_ok = 1;
      end
    end
    e_cls = (cnt == 0) ? 2'd0 : ((cnt == 1) ? 2'd1 : 2'd2);
    e_grant = !en || any_ok;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] addrs [10];
    logic [PW-1:0] pids [2];
    string tag;
    addrs = '{32'h0FFF, 32'h1000, 32'h101F, 32'h1900, 32'h1FFF,
              32'h2000, 32'h4000, 32'h401F, 32'h4020, 32'h8100};
    pids = '{8'h53, 8'h6A};
    // R1: low bits of bounds are nonzero on purpose
    r_lo[0] = 32'h100F; r_hi[0] = 32'h1FE0; r_vld[0] = 1;
    r_lo[1] = 32'h1800; r_hi[1] = 32'h2000; r_vld[1] = 1;
    r_lo[2] = 32'h4000; r_hi[2] = 32'h4000; r_vld[2] = 1;
    r_lo[3] = 32'h8000; r_hi[3] = 32'h8FFF; r_vld[3] = 0; // R2: invalid region
    for (int r = 0; r < NREG; r++) begin r_pid[r] = 8'h5A; r_msk[r] = 8'h0F; end
    for (int r = 0; r < NREG; r++) begin
      for (int m = 0; m < NFULL; m++) r_rx[r][m] = '0;
      for (int m = 0; m < NRW; m++) r_rw[r][m] = '0;
    end
    pack();
    repeat (3) @(negedge clk);
    chk("R10", "reset valid", int'(res_valid), 0);
    chk("R10", "reset grant", int'(res_grant), 0);
    chk("R10", "reset fault", int'(res_fault), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "idle valid", int'(res_valid), 0);
    for (int t = 0; t < 6; t++) begin
      for (int r = 0; r < NREG; r++) begin
        for (int m = 0; m < NFULL; m++) r_rx[r][m] = 6'((t*37 + r*11 + m*5 + 3) % 64);
        for (int m = 0; m < NRW; m++) r_rw[r][m] = 2'((t*13 + r*7 + m*3) % 4);
      end
      pack();
      for (int ai = 0; ai < 10; ai++)
      for (int m = 0; m < NFULL + NRW; m++)
      for (int k = 0; k < 4; k++)
      for (int s = 0; s < 2; s++)
      for (int p = 0; p < 2; p++)
      for (int e = 0; e < 2; e++) begin
        acc_valid = 1; acc_addr = addrs[ai]; acc_master = MW'(m);
        acc_kind = 2'(k); acc_super = s[0]; acc_pid = pids[p]; glb_en = e[0];
        model(addrs[ai], m, k, s[0], pids[p], e[0]);
        @(negedge clk);
        if (!e[0]) tag = "R7";
        else if (k == 3) tag = "R11";
        else if (m >= NFULL) tag = "R5";
        else if (ai >= 6 && ai <= 7) tag = "R6";
        else if (e_cls == 2) tag = "R8";
        else if (s != 0) tag = "R4";
        else tag = "R3";
        chk(tag, "grant", int'(res_grant), int'(e_grant));
        chk("R10", "fault", int'(res_fault), int'(!e_grant));
        chk("R9", "class", int'(res_class), int'(e_cls));
        chk((ai == 9) ? "R2" : "R1", "hits", int'(res_hits), int'(e_hits));
      end
    end
    acc_valid = 0;
    @(negedge clk);
    chk("R10", "valid drop", int'(res_valid), 0);
    chk("R10", "grant drop", int'(res_grant), 0);
    chk("R10", "hits drop", int'(res_hits), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule